// File: doc/BRIEF.md
# Serial GPIO Input Interrupt Unit

This block turns the input values of a serial GPIO chain into interrupts. The serial shifter is not part of it. Each time a burst completes, the shifter presents one flat vector of every sampled input together with a one-cycle valid strobe. The pins form a grid of up to 32 ports by up to 4 bit indices. Bit index `b` of port `p` sits at position `b*NUM_PORTS + p` of the sample vector.

For every pin, the unit compares the new sample with the previously captured one, or checks it against an active level. A match raises a pending flag. Software works through a small word-addressed register window. It selects each pin's trigger type and level polarity, masks pins per bit index, clears pending flags by writing ones, and reads back the enabled pending pins. A single interrupt line reports any enabled pending pin, gated by a master enable.

Register words are organised by bit index, and within each word port `p` is bit `p`. The two-bit trigger type of a pin is split over two words: its low bit is in trigger word `b` and its high bit is in trigger word `4+b`.

Top module: `sgio_irq_unit`

## Requirements
- R1: After reset every register word reads zero, every pending flag is clear and `irq` is low.
- R2: The register window maps as follows. Word 0x00 is the control word, and only bit 0 (the master enable) is stored and read back. Words 0x04+b are the per-pin enables. Words 0x08+b are the level polarities. Words 0x0C+b are the acknowledge words, which always read zero. Words 0x10+b are the identification words, which are read-only, so writes to them change nothing. Words 0x18+i, for i from 0 to 7, are the trigger words. The enable, polarity and trigger words read back the value last written to them.
- R3: A pin's trigger code is {trigger word 4+b bit p, trigger word b bit p}. Code 0 means level. Code 1 means any change. Code 2 means a 1-to-0 change. Code 3 means a 0-to-1 change.
- R4: Edge detection happens only on a strobe cycle, and compares the new sample with the sample captured on the previous strobe. The first strobe after reset only captures, so it raises no edge.
- R5: For code 0, polarity bit 0 makes a 1 the active level and polarity bit 1 makes a 0 the active level. Every strobe that sees the active level sets pending, including the strobe right after an acknowledge.
- R6: Writing acknowledge word b clears the pending flag of every port whose data bit is 1, and leaves the others alone. If a detection and an acknowledge hit the same pin in the same cycle, the pin ends up pending.
- R7: Identification word b reads pending AND enable for bit index b. A pending flag is kept while the pin's enable is 0, and it shows up as soon as the enable is set.
- R8: `irq` is high exactly when the master enable is 1 and at least one identification bit is 1.
- R9: When `smp_valid` is low, the sample vector is ignored. No pending flag is set and the captured previous sample does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe: a new burst of samples is present |
| smp_bits | input | NUM_BITS*NUM_PORTS | Sampled inputs, bit index b of port p at b*NUM_PORTS+p |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 6 | Register word address |
| cfg_wdata | input | NUM_PORTS | Register write data |
| cfg_rdata | output | NUM_PORTS | Register read data (combinational on cfg_addr) |
| irq | output | 1 | Combined interrupt request |

## Verification
The interesting collision is a detection and an acknowledge that land on the same pin in the same cycle. This happens when software acknowledges a pin while a new burst arrives that still sees the pin at its active level, or that sees a fresh edge. The bench creates this case directly: it writes the acknowledge word in the same cycle as a strobe that holds a low-active pin low. It then requires the identification word to show the pin still pending. The random phase also overlaps acknowledge writes with strobes, and a bench model in which the set wins judges the outcome every cycle.

// File: rtl/sgio_irq_pkg.sv
package sgio_irq_pkg;

    localparam int MAX_BITS = 4;
    localparam int ADDR_W   = 6;

    // register window word addresses
    localparam int A_CTRL  = 'h00;
    localparam int A_ENA   = 'h04;
    localparam int A_POL   = 'h08;
    localparam int A_ACK   = 'h0C;
    localparam int A_IDENT = 'h10;
    localparam int A_TRG   = 'h18;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_ANY   = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_RISE  = 2'd3
    } trig_e;

    typedef enum logic [2:0] {
        G_NONE,
        G_CTRL,
        G_ENA,
        G_POL,
        G_ACK,
        G_IDENT,
        G_TRG
    } grp_e;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] idx;
    } dec_t;

    // map a word address onto a register group and the row inside it
    function automatic dec_t decode_addr(logic [ADDR_W-1:0] a, int nbits);
        dec_t d;
        int   ai;
        d.grp = G_NONE;
        d.idx = '0;
        ai    = int'(a);
        if (ai == A_CTRL) begin
            d.grp = G_CTRL;
        end else if (ai >= A_ENA && ai < A_ENA + nbits) begin
            d.grp = G_ENA;
            d.idx = 3'(ai - A_ENA);
        end else if (ai >= A_POL && ai < A_POL + nbits) begin
            d.grp = G_POL;
            d.idx = 3'(ai - A_POL);
        end else if (ai >= A_ACK && ai < A_ACK + nbits) begin
            d.grp = G_ACK;
            d.idx = 3'(ai - A_ACK);
        end else if (ai >= A_IDENT && ai < A_IDENT + nbits) begin
            d.grp = G_IDENT;
            d.idx = 3'(ai - A_IDENT);
        end else if (ai >= A_TRG && ai < A_TRG + 2*MAX_BITS &&
                     ((ai - A_TRG) % MAX_BITS) < nbits) begin
            d.grp = G_TRG;
            d.idx = 3'(ai - A_TRG);
        end
        return d;
    endfunction

    // one pin: does this strobe raise a detection?
    function automatic logic pin_event(trig_e t, logic pol, logic primed,
                                       logic prv, logic cur);
        logic r;
        r = 1'b0;
        case (t)
            TRIG_LEVEL: r = cur ^ pol;
            TRIG_ANY:   r = primed & (cur ^ prv);
            TRIG_FALL:  r = primed & prv & ~cur;
            TRIG_RISE:  r = primed & ~prv & cur;
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sgio_irq_regs.sv
module sgio_irq_regs
    import sgio_irq_pkg::*;
#(
    parameter int NP = 32,
    parameter int NB = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [NP-1:0]         wdata,
    input  logic [NB-1:0][NP-1:0] ident,
    output logic [NP-1:0]         rdata,
    output logic                  master_en,
    output logic [NB-1:0][NP-1:0] en_q,
    output logic [NB-1:0][NP-1:0] pol_q,
    output logic [NB-1:0][NP-1:0] trg_lo,
    output logic [NB-1:0][NP-1:0] trg_hi,
    output logic [NB-1:0][NP-1:0] ack_clr
);

    dec_t dec;
    assign dec = decode_addr(addr, NB);

    always_ff @(posedge clk) begin
        if (rst) begin
            master_en <= 1'b0;
        end else if (we && dec.grp == G_CTRL) begin
            master_en <= wdata[0];
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_row
        logic hit_en, hit_pol, hit_lo, hit_hi, hit_ack;
        assign hit_en  = we && dec.grp == G_ENA && dec.idx == 3'(b);
        assign hit_pol = we && dec.grp == G_POL && dec.idx == 3'(b);
        assign hit_lo  = we && dec.grp == G_TRG && dec.idx == 3'(b);
        assign hit_hi  = we && dec.grp == G_TRG && dec.idx == 3'(MAX_BITS + b);
        assign hit_ack = we && dec.grp == G_ACK && dec.idx == 3'(b);

        assign ack_clr[b] = hit_ack ? wdata : '0;

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[b]   <= '0;
                pol_q[b]  <= '0;
                trg_lo[b] <= '0;
                trg_hi[b] <= '0;
            end else begin
                if (hit_en)  en_q[b]   <= wdata;
                if (hit_pol) pol_q[b]  <= wdata;
                if (hit_lo)  trg_lo[b] <= wdata;
                if (hit_hi)  trg_hi[b] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (dec.grp)
            G_CTRL: rdata[0] = master_en;
            G_ENA: begin
                for (int b = 0; b < NB; b++)
                    if (dec.idx == 3'(b)) rdata = en_q[b];
            end
            G_POL: begin
                for (int b = 0; b < NB; b++)
                    if (dec.idx == 3'(b)) rdata = pol_q[b];
            end
            G_IDENT: begin
                for (int b = 0; b < NB; b++)
                    if (dec.idx == 3'(b)) rdata = ident[b];
            end
            G_TRG: begin
                for (int b = 0; b < NB; b++) begin
                    if (dec.idx == 3'(b))            rdata = trg_lo[b];
                    if (dec.idx == 3'(MAX_BITS + b)) rdata = trg_hi[b];
                end
            end
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/sgio_irq_detect.sv
module sgio_irq_detect
    import sgio_irq_pkg::*;
#(
    parameter int NP = 32,
    parameter int NB = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  logic [NB*NP-1:0]      smp_bits,
    input  logic [NB-1:0][NP-1:0] trg_lo,
    input  logic [NB-1:0][NP-1:0] trg_hi,
    input  logic [NB-1:0][NP-1:0] pol_q,
    output logic [NB-1:0][NP-1:0] evt
);

    logic [NB-1:0][NP-1:0] cur;
    logic [NB-1:0][NP-1:0] prev_q;
    logic                  primed_q;

    assign cur = smp_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (smp_valid) begin
            prev_q   <= cur;
            primed_q <= 1'b1;
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_bit
        for (genvar p = 0; p < NP; p++) begin : g_port
            trig_e code;
            assign code = trig_e'({trg_hi[b][p], trg_lo[b][p]});
            assign evt[b][p] = smp_valid &
                pin_event(code, pol_q[b][p], primed_q, prev_q[b][p], cur[b][p]);
        end
    end

endmodule

// File: rtl/sgio_irq_pend.sv
module sgio_irq_pend #(
    parameter int NP = 32,
    parameter int NB = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NB-1:0][NP-1:0] evt,
    input  logic [NB-1:0][NP-1:0] ack_clr,
    input  logic [NB-1:0][NP-1:0] en_q,
    output logic [NB-1:0][NP-1:0] pend_q,
    output logic [NB-1:0][NP-1:0] ident
);

    for (genvar b = 0; b < NB; b++) begin : g_row
        // a detection in the acknowledge cycle survives
        always_ff @(posedge clk) begin
            if (rst) pend_q[b] <= '0;
            else     pend_q[b] <= (pend_q[b] & ~ack_clr[b]) | evt[b];
        end
        assign ident[b] = pend_q[b] & en_q[b];
    end

endmodule

// File: rtl/sgio_irq_unit.sv
module sgio_irq_unit
    import sgio_irq_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int NUM_BITS  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          smp_valid,
    input  logic [NUM_BITS*NUM_PORTS-1:0] smp_bits,
    input  logic                          cfg_we,
    input  logic [ADDR_W-1:0]             cfg_addr,
    input  logic [NUM_PORTS-1:0]          cfg_wdata,
    output logic [NUM_PORTS-1:0]          cfg_rdata,
    output logic                          irq
);

    localparam int NP = NUM_PORTS;
    localparam int NB = NUM_BITS;

    logic                  master_q;
    logic [NB-1:0][NP-1:0] en_w, pol_w, lo_w, hi_w, ack_w, evt_w, pend_q, ident_w;

    sgio_irq_regs #(.NP(NP), .NB(NB)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ident     (ident_w),
        .rdata     (cfg_rdata),
        .master_en (master_q),
        .en_q      (en_w),
        .pol_q     (pol_w),
        .trg_lo    (lo_w),
        .trg_hi    (hi_w),
        .ack_clr   (ack_w)
    );

    sgio_irq_detect #(.NP(NP), .NB(NB)) u_detect (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .smp_bits  (smp_bits),
        .trg_lo    (lo_w),
        .trg_hi    (hi_w),
        .pol_q     (pol_w),
        .evt       (evt_w)
    );

    sgio_irq_pend #(.NP(NP), .NB(NB)) u_pend (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt_w),
        .ack_clr (ack_w),
        .en_q    (en_w),
        .pend_q  (pend_q),
        .ident   (ident_w)
    );

    assign irq = master_q & (|ident_w);

endmodule

// File: rtl/sgio_irq_chk.sv
module sgio_irq_chk
    import sgio_irq_pkg::*;
#(
    parameter int NP = 32,
    parameter int NB = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  irq,
    input logic                  master_en,
    input logic                  smp_valid,
    input logic                  cfg_we,
    input logic [ADDR_W-1:0]     cfg_addr,
    input logic [NP-1:0]         cfg_wdata,
    input logic [NB-1:0][NP-1:0] pend,
    input logic [NB-1:0][NP-1:0] ident
);

    dec_t          dec;
    logic [NB-1:0] ack_hit;
    logic          any_ack;
    logic          rst_d;

    assign dec = decode_addr(cfg_addr, NB);
    for (genvar b = 0; b < NB; b++) begin : g_hit
        assign ack_hit[b] = cfg_we && dec.grp == G_ACK && dec.idx == 3'(b);
    end
    assign any_ack = |ack_hit;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        // R1: first cycle out of reset is quiet
        if (!rst && rst_d)
            p_reset_quiet_r1: assert (pend == '0 && !irq);
    end

    // R9: without strobe or acknowledge nothing pending moves
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!smp_valid && !any_ack) |=> pend == $past(pend));

    // R9: no new pending flag without a strobe
    p_no_set_r9: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> (pend & ~$past(pend)) == '0);

    for (genvar b = 0; b < NB; b++) begin : g_ack
        // R6: acknowledged ports are clear when no strobe competes
        p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
            (ack_hit[b] && !smp_valid) |=> (pend[b] & $past(cfg_wdata)) == '0);
    end

    // R8: master enable gates the line
    p_irq_master_r8: assert property (@(posedge clk) disable iff (rst)
        !master_en |-> !irq);

    // R8: line needs an identified pin
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> ident != '0);

endmodule

bind sgio_irq_unit sgio_irq_chk #(.NP(NUM_PORTS), .NB(NUM_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .irq       (irq),
    .master_en (master_q),
    .smp_valid (smp_valid),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .pend      (pend_q),
    .ident     (ident_w)
);

// File: tb/tb_sgio_irq_unit.sv
`timescale 1ns/1ps
module tb_sgio_irq_unit;

    localparam int NP = 32;
    localparam int NB = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_valid = 1'b0;
    logic [NB*NP-1:0] smp_bits = '0;
    logic             cfg_we = 1'b0;
    logic [5:0]       cfg_addr = '0;
    logic [NP-1:0]    cfg_wdata = '0;
    logic [NP-1:0]    cfg_rdata;
    logic             irq;

    sgio_irq_unit #(.NUM_PORTS(NP), .NUM_BITS(NB)) dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_bits(smp_bits),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // bench model of the register window and pin state
    logic [31:0] m_en[4], m_pol[4], m_trg[8], m_pend[4], m_prev[4];
    bit          m_primed, m_master;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit m_irq();
        bit r = 0;
        for (int b = 0; b < 4; b++) if ((m_pend[b] & m_en[b]) != 0) r = 1;
        return m_master && r;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        int ai = int'(a);
        if (ai == 0)                 return {31'd0, m_master};
        if (ai >= 4 && ai < 8)       return m_en[ai-4];
        if (ai >= 8 && ai < 12)      return m_pol[ai-8];
        if (ai >= 16 && ai < 20)     return m_pend[ai-16] & m_en[ai-16];
        if (ai >= 24 && ai < 32)     return m_trg[ai-24];
        return 32'd0;
    endfunction

    task automatic m_reset();
        for (int b = 0; b < 4; b++) begin
            m_en[b] = 0; m_pol[b] = 0; m_pend[b] = 0; m_prev[b] = 0;
            m_trg[b] = 0; m_trg[b+4] = 0;
        end
        m_primed = 0; m_master = 0;
    endtask

    // one clock: drive, advance model, check line and a random ident row
    task automatic step(bit we, logic [5:0] a, logic [31:0] wd,
                        bit sv, logic [127:0] bits);
        logic [31:0] ev[4];
        int ai = int'(a);
        int rb;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        smp_valid = sv; smp_bits = bits;
        for (int b = 0; b < 4; b++) begin
            ev[b] = 0;
            for (int p = 0; p < 32; p++) begin
                logic c, pv;
                int code;
                c    = bits[b*32+p];
                pv   = m_prev[b][p];
                code = {m_trg[b+4][p], m_trg[b][p]};
                if (sv) begin
                    case (code)
                        0: ev[b][p] = c ^ m_pol[b][p];
                        1: ev[b][p] = m_primed && (c != pv);
                        2: ev[b][p] = m_primed && pv && !c;
                        default: ev[b][p] = m_primed && !pv && c;
                    endcase
                end
            end
        end
        @(posedge clk);
        #1;
        for (int b = 0; b < 4; b++) begin
            logic [31:0] clr = (we && ai == 12 + b) ? wd : 32'd0;
            m_pend[b] = (m_pend[b] & ~clr) | ev[b];
            if (sv) m_prev[b] = bits[b*32 +: 32];
        end
        if (sv) m_primed = 1;
        if (we) begin
            if (ai == 0)                  m_master = wd[0];
            else if (ai >= 4 && ai < 8)   m_en[ai-4] = wd;
            else if (ai >= 8 && ai < 12)  m_pol[ai-8] = wd;
            else if (ai >= 24 && ai < 32) m_trg[ai-24] = wd;
        end
        cfg_we = 0; smp_valid = 0;
        chk("R8 irq", {31'd0, irq}, {31'd0, m_irq()});
        rb = $urandom % 4;
        cfg_addr = 6'(16 + rb);
        #1;
        chk("R7 ident", cfg_rdata, m_read(6'(16 + rb)));
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        cfg_we = 0; smp_valid = 0; cfg_addr = a;
        #1;
        chk(req, cfg_rdata, exp);
    endtask

    localparam logic [127:0] P31 = 128'd1 << 35;   // port 3, bit index 1

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [127:0] cur;
        void'($urandom(32'd20240611));
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        for (int a = 0; a < 64; a++) rd(6'(a), 32'd0, "R1 reg");

        // R2: readback, read-only and write-only words
        step(1, 6'h04, 32'hA5A5_A5A5, 0, 0);
        rd(6'h04, 32'hA5A5_A5A5, "R2 enable");
        step(1, 6'h10, 32'hFFFF_FFFF, 0, 0);
        rd(6'h10, 32'd0, "R2 ident write ignored");
        step(1, 6'h0C, 32'hFFFF_FFFF, 0, 0);
        rd(6'h0C, 32'd0, "R2 ack reads zero");
        step(1, 6'h00, 32'hFFFF_FFFF, 0, 0);
        rd(6'h00, 32'd1, "R2 ctrl bit0 only");
        step(1, 6'h1D, 32'h1234_5678, 0, 0);
        rd(6'h1D, 32'h1234_5678, "R2 trigger");
        step(1, 6'h1D, 0, 0, 0);
        step(1, 6'h04, 0, 0, 0);

        // R4: first strobe only captures; R3 any-change code
        step(1, 6'h19, 32'h8, 0, 0);
        step(1, 6'h05, 32'h8, 0, 0);
        step(0, 0, 0, 1, P31);
        rd(6'h11, 32'd0, "R4 first strobe no edge");
        step(0, 0, 0, 1, 0);
        rd(6'h11, 32'h8, "R3 any change");
        chk("R8 irq high", {31'd0, irq}, 32'd1);

        // R6: acknowledge
        step(1, 6'h0D, 32'h8, 0, 0);
        rd(6'h11, 32'd0, "R6 ack clears");
        chk("R8 irq low", {31'd0, irq}, 32'd0);

        // R9: samples without strobe ignored
        step(0, 0, 0, 0, P31);
        rd(6'h11, 32'd0, "R9 no strobe no pending");
        step(0, 0, 0, 1, P31);
        rd(6'h11, 32'h8, "R9 previous sample kept");

        // R3: falling then rising
        step(1, 6'h0D, 32'h8, 0, 0);
        step(1, 6'h19, 32'h0, 0, 0);
        step(1, 6'h1D, 32'h8, 0, 0);
        step(0, 0, 0, 1, P31);
        rd(6'h11, 32'd0, "R3 fall ignores steady 1");
        step(0, 0, 0, 1, 0);
        rd(6'h11, 32'h8, "R3 fall");
        step(1, 6'h0D, 32'h8, 0, 0);
        step(1, 6'h19, 32'h8, 0, 0);
        step(0, 0, 0, 1, 0);
        rd(6'h11, 32'd0, "R3 rise ignores steady 0");
        step(0, 0, 0, 1, P31);
        rd(6'h11, 32'h8, "R3 rise");
        step(1, 6'h0D, 32'h8, 0, 0);
        step(0, 0, 0, 1, P31);
        rd(6'h11, 32'd0, "R3 rise no repeat");

        // R5: low-active level on port 0, bit index 0
        step(1, 6'h08, 32'h1, 0, 0);
        step(1, 6'h04, 32'h1, 0, 0);
        step(0, 0, 0, 1, P31);
        rd(6'h10, 32'h1, "R5 low active");
        step(1, 6'h0C, 32'h1, 0, 0);
        rd(6'h10, 32'h0, "R6 level ack");
        step(0, 0, 0, 1, P31);
        rd(6'h10, 32'h1, "R5 re-set after ack");
        step(1, 6'h0C, 32'h1, 1, P31);
        rd(6'h10, 32'h1, "R6 set wins over ack");
        step(1, 6'h0C, 32'h1, 0, 0);
        step(0, 0, 0, 1, P31 | 128'd1);
        rd(6'h10, 32'h0, "R5 inactive level");

        // R7: latent pending
        step(1, 6'h04, 32'h0, 0, 0);
        step(0, 0, 0, 1, P31);
        rd(6'h10, 32'h0, "R7 masked");
        chk("R7 irq masked", {31'd0, irq}, 32'd0);
        step(1, 6'h04, 32'h1, 0, 0);
        rd(6'h10, 32'h1, "R7 appears on enable");

        // R8: master gate
        step(1, 6'h00, 32'h0, 0, 0);
        chk("R8 master off", {31'd0, irq}, 32'd0);
        step(1, 6'h00, 32'h1, 0, 0);
        chk("R8 master on", {31'd0, irq}, 32'd1);

        // random phase
        cur = P31;
        for (int i = 0; i < 3000; i++) begin
            bit          we, sv;
            logic [5:0]  a;
            logic [31:0] wd;
            int          k;
            we = ($urandom % 10) < 4;
            sv = ($urandom % 10) < 5;
            k  = $urandom % 6;
            case (k)
                0: a = 6'h00;
                1: a = 6'(4 + $urandom % 4);
                2: a = 6'(8 + $urandom % 4);
                3: a = 6'(12 + $urandom % 4);
                4: a = 6'(24 + $urandom % 8);
                default: a = 6'($urandom % 64);
            endcase
            wd = $urandom;
            if (a == 6'h00) wd[0] = ($urandom % 4) != 0;
            for (int w = 0; w < 4; w++)
                cur[w*32 +: 32] = cur[w*32 +: 32] ^ ($urandom & $urandom & $urandom);
            step(we, a, wd, sv, cur);
            if (i % 100 == 99)
                for (int a2 = 0; a2 < 64; a2 += 1) rd(6'(a2), m_read(6'(a2)), "R2 sweep");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule